// File: doc/BRIEF.md
# Presettable Four-Bit Counter with Split Count Enables

This block is a small synchronous counter that can be cleared, preset from a data bus, or advanced by one on each rising clock edge. Two separate enables must both be high for the count to advance. Only one of them, the chain enable, qualifies the carry output. A chain of counters can therefore be paused from one shared enable without producing a false carry, while the carry of each stage feeds the chain enable of the next stage.

A parameter selects the counting variant. In binary mode the register runs through sixteen states and the clear is sampled on the clock edge. In decade mode the register runs 0 to 9 and then returns to 0, and the clear forces zero as soon as it goes low, without waiting for a clock edge. A preset value that lies outside the decade range still advances by one per clock. It passes through the four-bit wrap and then re-enters the 0 to 9 range.

Top module: `presettable_counter`

## Requirements
- R1: While `clrN` is low, the next result is `count` = 0, whatever `loadN`, `enCount`, `enChain` and `dataIn` are doing.
- R2: With `clrN` high and `loadN` low, a rising edge copies `dataIn` into `count`, whatever the enables are doing.
- R3: With `clrN` and `loadN` high and both `enCount` and `enChain` high, a rising edge adds one to `count`.
- R4: With `clrN` and `loadN` high and either enable low, `count` keeps its value across the edge.
- R5: The terminal count is 15 in binary mode (`DECADE`=0) and 9 in decade mode (`DECADE`=1). Incrementing from the terminal count gives 0.
- R6: `carryOut` is high exactly when `enChain` is high and `count` equals the terminal count. `enCount` has no effect on it.
- R7: In binary mode, `clrN` going low between edges leaves `count` unchanged until the next rising edge, which then gives 0.
- R8: In decade mode, `clrN` going low sets `count` to 0 before the next rising edge.
- R9: In decade mode, a preset value from 10 to 15 advances by one per enabled edge, and 15 is followed by 0.
- R10: When the `carryOut` of a decade stage drives the `enChain` of a second stage, and both stages share `enCount`, the pair counts 00 to 99 in decimal and then returns to 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clrN | input | 1 | Active-low clear; synchronous in binary mode, asynchronous in decade mode |
| loadN | input | 1 | Active-low parallel preset |
| enCount | input | 1 | Count enable that does not affect the carry |
| enChain | input | 1 | Count enable that also qualifies the carry |
| dataIn | input | WIDTH | Preset value |
| count | output | WIDTH | Present count |
| carryOut | output | 1 | Terminal count qualified by `enChain` |

## Verification
The bench builds one stand-alone instance with `DECADE`=0 and two instances with `DECADE`=1, wired as a two-digit cascade. The binary instance covers the sixteen-state wrap and the clear that waits for an edge. The decade pair covers the asynchronous clear, the recovery of out-of-range presets, and the carry handoff between digits over a complete 00 to 99 cycle. Every instance uses the default `WIDTH` of 4, which is the only width at which decade mode has a meaning.

// File: rtl/counter_pkg.sv
package counter_pkg;

  // Strobes passed from the control module to the datapath
  typedef struct packed {
    logic clear;   // synchronous clear
    logic load;    // parallel preset
    logic inc;     // advance by one
  } ctrl_strobes_t;

endpackage

// File: rtl/counter_ctrl.sv
module counter_ctrl
  import counter_pkg::*;
(
  input  logic          clrN,
  input  logic          loadN,
  input  logic          enCount,
  input  logic          enChain,
  input  logic          atTerm,
  output ctrl_strobes_t strobes,
  output logic          carryOut
);

  // Priority: clear, then load, then count
  always_comb begin
    strobes.clear = ~clrN;
    strobes.load  = clrN & ~loadN;
    strobes.inc   = clrN & loadN & enCount & enChain;
  end

  // The carry is qualified only by the chain enable
  assign carryOut = enChain & atTerm;

endmodule

// File: rtl/counter_datapath.sv
module counter_datapath
  import counter_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             asyncClrN,
  input  ctrl_strobes_t    strobes,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             atTerm
);

  localparam logic [WIDTH-1:0] TERM_VALUE = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};
  localparam logic [WIDTH-1:0] ONE        = WIDTH'(1);

  logic [WIDTH-1:0] countQ;
  logic [WIDTH-1:0] countNext;

  assign atTerm = (countQ == TERM_VALUE);

  always_comb begin
    if (strobes.clear)     countNext = '0;
    else if (strobes.load) countNext = dataIn;
    else if (strobes.inc)  countNext = atTerm ? '0 : countQ + ONE;
    else                   countNext = countQ;
  end

  always_ff @(posedge clk or negedge asyncClrN) begin
    if (!asyncClrN) countQ <= '0;
    else            countQ <= countNext;
  end

  assign count = countQ;

endmodule

// File: rtl/presettable_counter.sv
module presettable_counter
  import counter_pkg::*;
#(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input  logic             clk,
  input  logic             clrN,
  input  logic             loadN,
  input  logic             enCount,
  input  logic             enChain,
  input  logic [WIDTH-1:0] dataIn,
  output logic [WIDTH-1:0] count,
  output logic             carryOut
);

  ctrl_strobes_t strobes;
  logic          atTerm;
  logic          asyncClrN;

  // The mode decides whether the clear bypasses the clock edge
  generate
    if (DECADE) begin : g_async_clear
      assign asyncClrN = clrN;
    end else begin : g_sync_clear
      assign asyncClrN = 1'b1;
    end
  endgenerate

  counter_ctrl u_ctrl (
    .clrN     (clrN),
    .loadN    (loadN),
    .enCount  (enCount),
    .enChain  (enChain),
    .atTerm   (atTerm),
    .strobes  (strobes),
    .carryOut (carryOut)
  );

  counter_datapath #(
    .WIDTH  (WIDTH),
    .DECADE (DECADE)
  ) u_dp (
    .clk       (clk),
    .asyncClrN (asyncClrN),
    .strobes   (strobes),
    .dataIn    (dataIn),
    .count     (count),
    .atTerm    (atTerm)
  );

endmodule

// File: rtl/presettable_counter_checker.sv
module presettable_counter_checker #(
  parameter int WIDTH  = 4,
  parameter bit DECADE = 1'b0
) (
  input logic             clk,
  input logic             clrN,
  input logic             loadN,
  input logic             enCount,
  input logic             enChain,
  input logic [WIDTH-1:0] dataIn,
  input logic [WIDTH-1:0] count,
  input logic             carryOut
);

  localparam logic [WIDTH-1:0] TERM_VALUE = DECADE ? WIDTH'(9) : {WIDTH{1'b1}};

  // Stays low until a clear has been sampled
  logic resetSeen = 1'b0;
  always_ff @(posedge clk) begin
    if (!clrN) resetSeen <= 1'b1;
  end

  p_clear_r1: assert property (@(posedge clk) disable iff (!resetSeen)
    !clrN |=> (count == '0));

  p_load_r2: assert property (@(posedge clk) disable iff (!resetSeen)
    (clrN && !loadN) |=> (!clrN || count == $past(dataIn)));

  p_inc_r3: assert property (@(posedge clk) disable iff (!resetSeen)
    (clrN && loadN && enCount && enChain && count != TERM_VALUE)
      |=> (!clrN || count == WIDTH'($past(count) + 1'b1)));

  p_hold_r4: assert property (@(posedge clk) disable iff (!resetSeen)
    (clrN && loadN && !(enCount && enChain)) |=> (!clrN || $stable(count)));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!resetSeen)
    (clrN && loadN && enCount && enChain && count == TERM_VALUE)
      |=> (!clrN || count == '0));

  p_carry_term_r6: assert property (@(posedge clk) disable iff (!resetSeen)
    carryOut |-> (enChain && count == TERM_VALUE));

  p_carry_gate_r6: assert property (@(posedge clk) disable iff (!resetSeen)
    !enChain |-> !carryOut);

endmodule

bind presettable_counter presettable_counter_checker #(
  .WIDTH  (WIDTH),
  .DECADE (DECADE)
) u_checker (
  .clk      (clk),
  .clrN     (clrN),
  .loadN    (loadN),
  .enCount  (enCount),
  .enChain  (enChain),
  .dataIn   (dataIn),
  .count    (count),
  .carryOut (carryOut)
);

// File: tb/tb_presettable_counter.sv
`timescale 1ns/1ps
module tb_presettable_counter;

  logic       clk = 1'b0;
  logic       clrN = 1'b0;
  logic       loadN = 1'b1;
  logic       enCount = 1'b0;
  logic       enChain = 1'b0;
  logic [3:0] dataIn = 4'd0;

  logic [3:0] binCount;
  logic       binCarry;
  logic [3:0] loCount;
  logic       loCarry;
  logic [3:0] hiCount;
  logic       hiCarry;

  int checkCount = 0;
  int failCount  = 0;

  always #2.5 clk = ~clk;

  presettable_counter #(.WIDTH(4), .DECADE(1'b0)) dut (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enCount(enCount), .enChain(enChain),
    .dataIn(dataIn), .count(binCount), .carryOut(binCarry)
  );

  presettable_counter #(.WIDTH(4), .DECADE(1'b1)) decLo (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enCount(enCount), .enChain(enChain),
    .dataIn(dataIn), .count(loCount), .carryOut(loCarry)
  );

  presettable_counter #(.WIDTH(4), .DECADE(1'b1)) decHi (
    .clk(clk), .clrN(clrN), .loadN(loadN), .enCount(enCount), .enChain(loCarry),
    .dataIn(dataIn), .count(hiCount), .carryOut(hiCarry)
  );

  typedef struct {
    bit         cascade;   // 0: binary instance, 1: decade pair
    logic [7:0] val;
    logic       carry;
    string      req;
  } item_t;

  item_t sb[$];

  // Bench-side model state
  logic [3:0] mBin = 4'd0;
  logic [3:0] mLo  = 4'd0;
  logic [3:0] mHi  = 4'd0;

  function automatic logic [3:0] modelNext(input logic [3:0] cur, input logic clr,
                                           input logic ld, input logic [3:0] d,
                                           input logic inc, input logic [3:0] term);
    if (!clr)     return 4'd0;
    else if (!ld) return d;
    else if (inc) return (cur == term) ? 4'd0 : cur + 4'd1;
    else          return cur;
  endfunction

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checkCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of inputs at the falling edge and queue the expected results
  task automatic step(input logic clr, input logic ld, input logic [3:0] d,
                      input logic ep, input logic et, input string req);
    logic loCarryPre;
    item_t it;
    @(negedge clk);
    clrN = clr; loadN = ld; dataIn = d; enCount = ep; enChain = et;
    loCarryPre = et && (mLo == 4'd9);
    mBin = modelNext(mBin, clr, ld, d, ep && et, 4'd15);
    mLo  = modelNext(mLo,  clr, ld, d, ep && et, 4'd9);
    mHi  = modelNext(mHi,  clr, ld, d, ep && loCarryPre, 4'd9);
    it.cascade = 1'b0; it.val = {4'd0, mBin};
    it.carry = et && (mBin == 4'd15); it.req = req;
    sb.push_back(it);
    it.cascade = 1'b1; it.val = {mHi, mLo};
    it.carry = et && (mLo == 4'd9) && (mHi == 4'd9); it.req = req;
    sb.push_back(it);
  endtask

  // Monitor: compare just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sb.size() > 0) begin
        item_t it;
        it = sb.pop_front();
        if (!it.cascade) begin
          check({it.req, " binary count"}, {4'd0, binCount}, it.val);
          check({it.req, " binary carry"}, {7'd0, binCarry}, {7'd0, it.carry});
        end else begin
          check({it.req, " decade pair"}, {hiCount, loCount}, it.val);
          check({it.req, " decade carry"}, {7'd0, hiCarry}, {7'd0, it.carry});
        end
      end
    end
  end

  initial begin
    #(5.0 * 200000);
    failCount++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

  initial begin
    // R1 reset state, then clear overriding load and the enables
    step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, "R1");
    step(1'b0, 1'b0, 4'd7, 1'b1, 1'b1, "R1");
    // R2: the preset wins over counting
    step(1'b1, 1'b0, 4'd5, 1'b1, 1'b1, "R2");
    // R3 and R5: count through the binary wrap and the decade wrap
    for (int i = 0; i < 14; i++) step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R3_R5");
    // R6: terminal count, enCount low, enChain high gives a carry
    step(1'b1, 1'b0, 4'd15, 1'b0, 1'b0, "R2");
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R6");
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R6");
    // R4: hold with enChain low
    step(1'b1, 1'b1, 4'd0, 1'b1, 1'b0, "R4");
    step(1'b1, 1'b1, 4'd0, 1'b0, 1'b0, "R4");
    // R7 and R8: clear falling between edges
    step(1'b1, 1'b0, 4'd7, 1'b0, 1'b0, "R2");
    @(negedge clk);
    clrN = 1'b0; loadN = 1'b1;
    #1;
    check("R7 binary waits for edge", {4'd0, binCount}, {4'd0, mBin});
    check("R8 decade clears at once", {hiCount, loCount}, 8'h00);
    mLo = 4'd0; mHi = 4'd0;
    step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, "R7_R8");
    // R9: out-of-range preset recovers through the four-bit wrap
    step(1'b1, 1'b0, 4'd12, 1'b0, 1'b0, "R9");
    for (int i = 0; i < 16; i++) step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R9");
    // R10: a complete two-digit cycle from 00
    step(1'b0, 1'b1, 4'd0, 1'b0, 1'b0, "R1");
    for (int i = 0; i < 104; i++) step(1'b1, 1'b1, 4'd0, 1'b1, 1'b1, "R10");
    // R10: a shared enCount pause stops both digits
    for (int i = 0; i < 3; i++) step(1'b1, 1'b1, 4'd0, 1'b0, 1'b1, "R10");
    @(negedge clk);
    @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checkCount, failCount);
    $finish;
  end

endmodule